// File: doc/BRIEF.md
# Time-Gated Transmit Queue Scheduler

This block opens and closes the transmit gate of each of up to two queues on a repeating schedule. Software programs a start instant, an open duration and a closed duration for every queue through a small memory-mapped register port. It then arms the queue through a shared control word. An armed queue holds its gate shut until the time-of-day input reaches the programmed start instant. From then on the gate is open for the open duration and shut for the closed duration, over and over.

Durations are counted in byte times of the current link. A divider derives these from the 8 ns reference clock, using a 2-bit link-speed input. A queue that is not armed keeps its gate open and behaves as a plain FIFO. While a queue is armed its timing registers are locked. A write that is refused sets a sticky error flag, and reading the control word clears that flag.

Top module: `tgate_sched_top`

## Requirements
- R1: After reset every gate output is 1, every running bit is 0, and every register reads 0.
- R2: Register map, by byte address: start time of queue q at 0x800+4q, 32 bits, with seconds in [31:30] and nanoseconds in [29:0]. Open time of queue q at 0x820+4q and closed time at 0x840+4q; each keeps only bits [16:0], and the upper bits read as 0. Control word at 0x880. Any other address reads 0.
- R3: In a write to the control word, bit q arms queue q and bit 16+q disarms it. If both are 1, disarm wins. A 0 bit changes nothing, and writing the arm bit of a queue that is already armed changes nothing.
- R4: A disarmed queue has its gate output at 1 and its running bit at 0.
- R5: An armed queue holds its gate at 0 until tod_sec_i equals start[31:30] and tod_nsec_i equals start[29:0]. The gate output becomes 1 at the first clock edge after a cycle in which both match.
- R6: After the start, the gate is 1 for exactly (open time) ticks and 0 for exactly (closed time) ticks, repeating. At 1 Gb/s this is that many clock cycles.
- R7: The tick period is 1 clock for speed_i = 2'b10 or 2'b11, 10 clocks for 2'b01 and 100 clocks for 2'b00.
- R8: A write to a timing register of a running queue is dropped, and it sets control-word bit 31. Bit 31 is cleared by the clock edge that ends a read of the control word.
- R9: A read of the control word returns the running bit of queue q in bit q, so the value is nonzero whenever any schedule is active.
- R10: An open time of 0 keeps an armed queue's gate at 0. An open time that is not 0 together with a closed time of 0 keeps the gate at 1 once the start has been reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, 8 ns period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe, used to clear the error flag on read |
| reg_addr_i | input | 12 | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, a combinational function of the address |
| speed_i | input | 2 | Link speed: 00 = 10 Mb/s, 01 = 100 Mb/s, 1x = 1 Gb/s |
| tod_sec_i | input | 2 | Time of day, seconds modulo 4 |
| tod_nsec_i | input | 30 | Time of day, nanoseconds |
| gate_open_o | output | 2 | Gate open, one bit per queue |
| running_o | output | 2 | Schedule active, one bit per queue |

## Verification
Read data is combinational, so the bench samples it 1 ns after it drives the address. A write to the control word changes the running bit at the next clock edge. A start match changes the gate at the first edge after the matching cycle, and every later phase change lands on the edge that carries the final tick of that phase. The bench samples on falling edges and counts every register on the path. For the slower speeds, phase alignment with the free-running divider is not fixed, so the bench measures the steady-state distance between two gate rising edges instead of an absolute cycle.

// File: rtl/tgate_pkg.sv
package tgate_pkg;
  localparam int unsigned ADDR_W     = 12;
  localparam int unsigned DATA_W     = 32;
  localparam logic [ADDR_W-1:0] START_BASE = 12'h800;
  localparam logic [ADDR_W-1:0] ON_BASE    = 12'h820;
  localparam logic [ADDR_W-1:0] OFF_BASE   = 12'h840;
  localparam logic [ADDR_W-1:0] CTRL_ADDR  = 12'h880;
  localparam int unsigned DIS_SHIFT  = 16;
  localparam int unsigned ERR_BIT    = 31;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ON   = 2'd2,
    ST_OFF  = 2'd3
  } q_state_e;

  function automatic logic [ADDR_W-1:0] q_addr(logic [ADDR_W-1:0] base, int unsigned q);
    return base + ADDR_W'(4 * q);
  endfunction
endpackage

// File: rtl/tgate_tick.sv
module tgate_tick #(
  parameter int unsigned DIV_1G   = 1,
  parameter int unsigned DIV_100M = 10,
  parameter int unsigned DIV_10M  = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] speed_i,
  output logic       tick_o
);
  localparam int unsigned CNT_W = $clog2(DIV_10M + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb begin
    unique case (speed_i)
      2'b00:   lim = CNT_W'(DIV_10M - 1);
      2'b01:   lim = CNT_W'(DIV_100M - 1);
      default: lim = CNT_W'(DIV_1G - 1);
    endcase
  end

  // >= so a speed change to a shorter period never strands the counter
  assign tick_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  p_no_back_to_back_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && speed_i == 2'b01) |=> (speed_i != 2'b01 || !tick_o));
  p_fast_every_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (speed_i[1] && $past(speed_i[1])) |-> tick_o);
endmodule

// File: rtl/tgate_regs.sv
module tgate_regs
  import tgate_pkg::*;
#(
  parameter int unsigned NUM_Q = 2,
  parameter int unsigned ON_W  = 17
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic                          re_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  input  logic [NUM_Q-1:0]              running_i,
  output logic [NUM_Q-1:0][DATA_W-1:0]  start_o,
  output logic [NUM_Q-1:0][ON_W-1:0]    on_o,
  output logic [NUM_Q-1:0][ON_W-1:0]    off_o,
  output logic [NUM_Q-1:0]              arm_o,
  output logic [NUM_Q-1:0]              disarm_o
);
  logic [NUM_Q-1:0] hit_st, hit_on, hit_off, lock_hit;
  logic hit_ctrl, err_q;

  assign hit_ctrl = (addr_i == CTRL_ADDR);

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    assign hit_st[q]   = (addr_i == q_addr(START_BASE, q));
    assign hit_on[q]   = (addr_i == q_addr(ON_BASE, q));
    assign hit_off[q]  = (addr_i == q_addr(OFF_BASE, q));
    assign lock_hit[q] = we_i && running_i[q] && (hit_st[q] || hit_on[q] || hit_off[q]);
    assign arm_o[q]    = we_i && hit_ctrl && wdata_i[q];
    assign disarm_o[q] = we_i && hit_ctrl && wdata_i[DIS_SHIFT + q];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        start_o[q] <= '0;
        on_o[q]    <= '0;
        off_o[q]   <= '0;
      end else if (we_i && !running_i[q]) begin
        if (hit_st[q])  start_o[q] <= wdata_i;
        if (hit_on[q])  on_o[q]    <= wdata_i[ON_W-1:0];
        if (hit_off[q]) off_o[q]   <= wdata_i[ON_W-1:0];
      end
    end

    p_locked_on_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && running_i[q] && hit_on[q]) |=> $stable(on_o[q]));
    p_locked_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && running_i[q] && hit_st[q]) |=> $stable(start_o[q]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= (|lock_hit) || (err_q && !(re_i && hit_ctrl));
  end

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lock_hit) |=> err_q);

  always_comb begin
    rdata_o = '0;
    if (hit_ctrl) begin
      rdata_o[NUM_Q-1:0] = running_i;
      rdata_o[ERR_BIT]   = err_q;
    end
    for (int q = 0; q < NUM_Q; q++) begin
      if (hit_st[q])  rdata_o = start_o[q];
      if (hit_on[q])  rdata_o = DATA_W'(on_o[q]);
      if (hit_off[q]) rdata_o = DATA_W'(off_o[q]);
    end
  end
endmodule

// File: rtl/tgate_queue.sv
module tgate_queue
  import tgate_pkg::*;
#(
  parameter int unsigned ON_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              arm_i,
  input  logic              disarm_i,
  input  logic [DATA_W-1:0] start_i,
  input  logic [ON_W-1:0]   on_i,
  input  logic [ON_W-1:0]   off_i,
  input  logic [1:0]        tod_sec_i,
  input  logic [29:0]       tod_nsec_i,
  output logic              gate_o,
  output logic              running_o
);
  q_state_e       st_q;
  logic [ON_W-1:0] cnt_q;
  logic            match;
  logic [ON_W:0]   cnt_nx;

  assign match  = (tod_sec_i == start_i[31:30]) && (tod_nsec_i == start_i[29:0]);
  assign cnt_nx = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (disarm_i) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (arm_i) st_q <= ST_WAIT;
        ST_WAIT: if (match) begin st_q <= ST_ON; cnt_q <= '0; end
        ST_ON: begin
          if (on_i == '0) begin
            st_q <= ST_OFF; cnt_q <= '0;
          end else if (tick_i && off_i != '0) begin
            if (cnt_nx >= {1'b0, on_i}) begin st_q <= ST_OFF; cnt_q <= '0; end
            else cnt_q <= cnt_nx[ON_W-1:0];
          end
        end
        ST_OFF: begin
          if (on_i != '0) begin
            if (off_i == '0) begin
              st_q <= ST_ON; cnt_q <= '0;
            end else if (tick_i) begin
              if (cnt_nx >= {1'b0, off_i}) begin st_q <= ST_ON; cnt_q <= '0; end
              else cnt_q <= cnt_nx[ON_W-1:0];
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign running_o = (st_q != ST_IDLE);
  assign gate_o    = (st_q == ST_IDLE) || (st_q == ST_ON && on_i != '0);

  p_idle_open_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o |-> gate_o);
  p_wait_shut_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT) |-> !gate_o);
  p_disarm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disarm_i |=> !running_o);
  p_arm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !disarm_i && !running_o) |=> running_o);
  p_zero_on_shut_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && on_i == '0) |-> !gate_o);
endmodule

// File: rtl/tgate_sched_top.sv
module tgate_sched_top
  import tgate_pkg::*;
#(
  parameter int unsigned NUM_Q = 2,
  parameter int unsigned ON_W  = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [11:0]       reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [1:0]        speed_i,
  input  logic [1:0]        tod_sec_i,
  input  logic [29:0]       tod_nsec_i,
  output logic [NUM_Q-1:0]  gate_open_o,
  output logic [NUM_Q-1:0]  running_o
);
  logic                         tick;
  logic [NUM_Q-1:0][DATA_W-1:0] start_r;
  logic [NUM_Q-1:0][ON_W-1:0]   on_r, off_r;
  logic [NUM_Q-1:0]             arm, disarm;

  tgate_tick i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .speed_i(speed_i),
    .tick_o (tick)
  );

  tgate_regs #(.NUM_Q(NUM_Q), .ON_W(ON_W)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .re_i     (reg_re_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .running_i(running_o),
    .start_o  (start_r),
    .on_o     (on_r),
    .off_o    (off_r),
    .arm_o    (arm),
    .disarm_o (disarm)
  );

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    tgate_queue #(.ON_W(ON_W)) i_queue (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick),
      .arm_i     (arm[q]),
      .disarm_i  (disarm[q]),
      .start_i   (start_r[q]),
      .on_i      (on_r[q]),
      .off_i     (off_r[q]),
      .tod_sec_i (tod_sec_i),
      .tod_nsec_i(tod_nsec_i),
      .gate_o    (gate_open_o[q]),
      .running_o (running_o[q])
    );
  end
endmodule

// File: tb/test_tgate_sched_top.sv
module test_tgate_sched_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0]  speed = 2'b10, sec = 2'b00, gate, run;
  logic [29:0] nsec = '0;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  tgate_sched_top i_tgate_sched_top (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .speed_i(speed), .tod_sec_i(sec), .tod_nsec_i(nsec),
    .gate_open_o(gate), .running_o(run));

  // {we, addr, wdata, expected read}
  localparam int NV = 7;
  localparam logic [76:0] VEC [NV] = '{
    {1'b1, 12'h800, 32'hC000_1234, 32'hC000_1234},
    {1'b1, 12'h820, 32'h000F_FFFF, 32'h0001_FFFF},
    {1'b1, 12'h844, 32'hFFFF_0005, 32'h0001_0005},
    {1'b1, 12'h804, 32'h1234_5678, 32'h1234_5678},
    {1'b0, 12'h848, 32'h0000_0000, 32'h0000_0000},
    {1'b0, 12'h880, 32'h0000_0000, 32'h0000_0000},
    {1'b1, 12'h824, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  // cycles between second and third rising edge of gate[q]
  task automatic period(input int q, output int per);
    int rises = 0, n = 0;
    logic prev = gate[q];
    per = -1;
    for (int i = 0; i < 3000 && rises < 3; i++) begin
      @(negedge clk);
      if (rises >= 2) n++;
      if (!prev && gate[q]) begin
        rises++;
        if (rises == 3) per = n;
      end
      prev = gate[q];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int per;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(gate == 2'b11, "R1 gate", 32'(gate), 32'h3);
    chk(run == 2'b00, "R1 running", 32'(run), 32'h0);
    rst_n = 1'b1;
    rd(12'h880, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(12'h840, d); chk(d == 0, "R1 off q0", d, 0);

    // R2 register map vectors
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) wr(VEC[i][75:64], VEC[i][63:32]);
      rd(VEC[i][75:64], d);
      chk(d == VEC[i][31:0], $sformatf("R2 vec%0d", i), d, VEC[i][31:0]);
    end

    // R5/R6 schedule on queue 0 at 1 Gb/s: open 3, shut 2
    speed = 2'b10; sec = 2'b01; nsec = 30'd999;
    wr(12'h800, {2'b01, 30'd1000});
    wr(12'h820, 32'd3);
    wr(12'h840, 32'd2);
    wr(12'h880, 32'h1);
    chk(run[0] == 1'b1, "R3 arm", 32'(run), 32'h1);
    chk(gate[0] == 1'b0, "R5 shut while waiting", 32'(gate), 32'h0);
    repeat (4) @(negedge clk);
    chk(gate[0] == 1'b0, "R5 shut before match", 32'(gate), 32'h0);
    nsec = 30'd1000;
    @(negedge clk);
    nsec = 30'd5;
    chk(gate[0] == 1'b1, "R5 open after match", 32'(gate), 32'h1);
    for (int i = 1; i < 10; i++) begin
      @(negedge clk);
      chk(gate[0] == ((i % 5) < 3), $sformatf("R6 phase cyc%0d", i), 32'(gate[0]), 32'((i % 5) < 3));
    end

    // R9 control read shows running
    rd(12'h880, d); chk(d[1:0] == 2'b01 && d != 0, "R9 ctrl running", d, 32'h1);

    // R8 lock
    wr(12'h820, 32'd7);
    rd(12'h820, d); chk(d == 32'd3, "R8 write dropped", d, 3);
    rd(12'h880, d); chk(d[31] == 1'b1, "R8 err set", d, 32'h8000_0001);
    rd(12'h880, d); chk(d[31] == 1'b0, "R8 err cleared", d, 32'h1);

    // R3 zero bits / re-arm have no effect, disarm wins
    wr(12'h880, 32'h0);
    chk(run == 2'b01, "R3 zero write", 32'(run), 32'h1);
    wr(12'h880, 32'h1);
    chk(run == 2'b01, "R3 re-arm", 32'(run), 32'h1);
    wr(12'h880, 32'h0001_0001);
    chk(run == 2'b00, "R3 disarm wins", 32'(run), 32'h0);
    chk(gate == 2'b11, "R4 disarmed open", 32'(gate), 32'h3);

    // R10 open time zero on queue 1
    wr(12'h804, {2'b10, 30'd77});
    wr(12'h824, 32'd0);
    wr(12'h844, 32'd5);
    sec = 2'b10; nsec = 30'd77;
    wr(12'h880, 32'h2);
    repeat (20) @(negedge clk);
    chk(gate[1] == 1'b0 && run[1], "R10 open zero", 32'(gate), 32'h1);
    wr(12'h880, 32'h0002_0000);
    // R10 closed time zero
    wr(12'h824, 32'd4);
    wr(12'h844, 32'd0);
    wr(12'h880, 32'h2);
    begin
      bit all_open = 1'b1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (i > 0 && !gate[1]) all_open = 1'b0;
      end
      chk(all_open, "R10 closed zero", 32'(gate), 32'h3);
    end
    wr(12'h880, 32'h0002_0000);

    // R7 tick period via schedule period
    nsec = 30'd0; sec = 2'b00;
    wr(12'h800, 32'd0);
    wr(12'h820, 32'd2);
    wr(12'h840, 32'd3);
    speed = 2'b01;
    wr(12'h880, 32'h1);
    period(0, per);
    chk(per == 50, "R7 100M period", 32'(per), 32'd50);
    wr(12'h880, 32'h0001_0000);
    wr(12'h820, 32'd1);
    wr(12'h840, 32'd1);
    speed = 2'b00;
    wr(12'h880, 32'h1);
    period(0, per);
    chk(per == 200, "R7 10M period", 32'(per), 32'd200);
    wr(12'h880, 32'h0001_0000);
    speed = 2'b11;
    wr(12'h880, 32'h1);
    period(0, per);
    chk(per == 2, "R7 speed 11 as 1G", 32'(per), 32'd2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule